// File: doc/BRIEF.md
# Crossbar Dataflow Array with Completion Interrupt

This block is a small dataflow engine. It holds four operand buffers that the host writes and four functional elements (ALUs). Each ALU picks its left and right operands through a crossbar. The crossbar can draw from any of the eight sources, which are the four buffers and the four ALU result registers. An ALU computes when every operand it needs is present and its own result register is empty. Chains and parallel groups are therefore formed by the select fields alone, and no instruction sequencing is involved.

A source stays full until every active ALU that selects it has taken the value. The host writes operands, waits for the interrupt, and then reads the results of the terminal ALUs. Reading a result empties that register, which in turn drops the interrupt. An ALU configured as IDLE takes no data and does not count toward completion.

Top module: `dfa_array`

## Requirements
- R1: After reset, all buffers and result registers are empty and every ALU is IDLE. Both `irq_o` and the status word read as zero.
- R2: Register map:
  - Offsets 0-3 are the operand buffers, write only; a read returns 0.
  - Offsets 4-7 are the ALU results.
  - Offsets 8-11 are the ALU configuration words: opcode in bits 2:0, left source in bits 6:4, right source in bits 10:8. Sources 0-3 are buffers and 4-7 are ALU results.
  - Offset 12 is status.

  A configuration write takes effect only when every buffer and result register is empty. Otherwise it is dropped and the error flag is set.
- R3: A buffer write is accepted only when the buffer is empty. A write to a full buffer is dropped, keeps the earlier value and sets the error flag.
- R4: Opcodes: 0 IDLE, 1 ADD, 2 SUB (left minus right), 3 MUL (low 16 bits), 4 AND, 5 OR, 6 XOR, 7 NOT. A result is registered one clock after the last needed operand becomes present, provided the ALU's result register is empty.
- R5: An IDLE ALU consumes nothing. A buffer write that no active ALU selects is dropped without error, and the buffer stays empty.
- R6: A source selected by several active ALUs stays full until each of them has taken it.
- R7: A result consumed by downstream ALUs empties by itself. In the chain (A+B)*C+D the final result appears three clocks after the last operand write.
- R8: `irq_o` is high when at least one ALU is active and every active ALU whose result feeds no active ALU holds a result.
- R9: Reading a full result returns it, empties it and clears the interrupt. Reading an empty result returns 0 and sets the error flag.
- R10: Status bits:
  - Bits 3:0 are the buffer full flags.
  - Bits 2j+5:2j+4 are the state of ALU j: 0 idle, 1 ready, 2 holding a result.
  - Bit 12 is the sticky error flag. Writing status with bit 12 set clears it.
- R11: NOT uses only its left source. Its right select is ignored and does not make that source a consumer target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; side effects at the clock edge |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level completion interrupt |

## Verification
The array is exercised with several configurations:
- A single adder, showing basic firing and result read-out.
- Two independent adders with operands arriving in stages. The interrupt must wait for both terminal ALUs.
- A three-deep chain with operands ordered so the last write starts the ripple. This shows per-stage latency and that intermediates empty without host action.
- One buffer shared by two ALUs, showing that release waits for the slower consumer.

Misuse patterns are also applied: overwriting a full buffer, writing an unconsumed buffer, reconfiguring while data is in flight, and reading an empty result. Each separates dropped stimulus from accepted stimulus through status and read data. A behavioural model tracks the interrupt and every read on each clock.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  localparam int NB      = 4;
  localparam int NA      = 4;
  localparam int NS      = NB + NA;
  localparam int SW      = $clog2(NS);
  localparam int OPW     = 3;
  localparam int CF_L    = 4;
  localparam int CF_R    = 8;
  localparam int A_OUT   = NB;
  localparam int A_CFG   = NB + NA;
  localparam int A_STAT  = NB + 2 * NA;
  localparam int ERR_BIT = NB + 2 * NA;

  typedef enum logic [OPW-1:0] {
    OP_IDLE = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MUL = 3'd3,
    OP_AND  = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_NOT = 3'd7
  } op_e;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READY = 2'd1, ST_WAIT = 2'd2} fe_state_e;
endpackage

// File: rtl/dfa_alu.sv
module dfa_alu import dfa_pkg::*; #(
  parameter int DW = 16
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MUL:  y_o = a_i * b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NOT:  y_o = ~a_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/dfa_xbar.sv
module dfa_xbar #(
  parameter int DW   = 16,
  parameter int NSRC = 8,
  parameter int NDST = 4,
  parameter int SELW = 3
) (
  input  logic [NSRC-1:0][DW-1:0] src_i,
  input  logic [NDST-1:0][SELW-1:0] sel_i,
  output logic [NDST-1:0][DW-1:0] dst_o
);
  for (genvar d = 0; d < NDST; d++) begin : g_dst
    assign dst_o[d] = src_i[sel_i[d]];
  end
endmodule

// File: rtl/dfa_slot.sv
// One source register: value, full flag and per-consumer pending mask.
module dfa_slot #(
  parameter int DW = 16,
  parameter int NA = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          flush_i,
  input  logic [DW-1:0] data_i,
  input  logic [NA-1:0] mask_i,
  input  logic [NA-1:0] clr_i,
  output logic          full_o,
  output logic [NA-1:0] pend_o,
  output logic [DW-1:0] data_o
);
  logic          full_q;
  logic [NA-1:0] pend_q;
  logic [DW-1:0] data_q;
  logic [NA-1:0] pend_left;

  assign pend_left = pend_q & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pend_q <= '0;
      data_q <= '0;
    end else if (flush_i) begin
      full_q <= 1'b0;
      pend_q <= '0;
    end else if (load_i) begin
      full_q <= 1'b1;
      pend_q <= mask_i;
      data_q <= data_i;
    end else if (|(pend_q & clr_i)) begin
      pend_q <= pend_left;
      if (pend_left == '0) full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign pend_o = pend_q;
  assign data_o = data_q;

  // R3: a held value is never replaced while full
  a_r3_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !flush_i |=> $stable(data_q));
  // R6: stays full while some consumer has not yet taken it
  a_r6_keep_until_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !flush_i && (pend_left != '0) |=> full_q);
endmodule

// File: rtl/dfa_array.sv
module dfa_array import dfa_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  op_e                   op_q [NA];
  logic [NA-1:0][SW-1:0] lsel_q, rsel_q;
  logic [NS-1:0]         full;
  logic [NS-1:0][NA-1:0] pend, cons, clr;
  logic [NS-1:0][DW-1:0] sdata;
  logic [NA-1:0][DW-1:0] opa, opb, res;
  logic [NA-1:0]         active, unary, fire, sink;
  logic                  err_q, wr_err, rd_err, cfg_ok;
  int                    a;

  assign a      = int'(addr_i);
  assign cfg_ok = (full == '0);

  always_comb begin
    for (int j = 0; j < NA; j++) begin
      active[j] = (op_q[j] != OP_IDLE);
      unary[j]  = (op_q[j] == OP_NOT);
    end
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < NA; j++)
        cons[s][j] = active[j] && ((int'(lsel_q[j]) == s) || (!unary[j] && int'(rsel_q[j]) == s));
    for (int j = 0; j < NA; j++) begin
      fire[j] = active[j] && !full[NB+j] && pend[lsel_q[j]][j] && (unary[j] || pend[rsel_q[j]][j]);
      sink[j] = active[j] && (cons[NB+j] == '0);
    end
    for (int s = 0; s < NS; s++) clr[s] = cons[s] & fire;
  end

  dfa_xbar #(.DW(DW), .NSRC(NS), .NDST(NA), .SELW(SW)) u_xbar_l (
    .src_i(sdata), .sel_i(lsel_q), .dst_o(opa));
  dfa_xbar #(.DW(DW), .NSRC(NS), .NDST(NA), .SELW(SW)) u_xbar_r (
    .src_i(sdata), .sel_i(rsel_q), .dst_o(opb));

  for (genvar j = 0; j < NA; j++) begin : g_alu
    dfa_alu #(.DW(DW)) u_alu (.op_i(op_q[j]), .a_i(opa[j]), .b_i(opb[j]), .y_o(res[j]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        op_q[j]   <= OP_IDLE;
        lsel_q[j] <= '0;
        rsel_q[j] <= '0;
      end else if (wr_en_i && a == A_CFG + j && cfg_ok) begin
        op_q[j]   <= op_e'(wdata_i[OPW-1:0]);
        lsel_q[j] <= wdata_i[CF_L +: SW];
        rsel_q[j] <= wdata_i[CF_R +: SW];
      end
    end

    // R2: configuration frozen while anything is in flight
    a_r2_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full != '0) |=> $stable(op_q[j]) && $stable(lsel_q[j]) && $stable(rsel_q[j]));
    // R5: an idle element never holds a result
    a_r5_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_q[j] == OP_IDLE |-> !full[NB+j]);
    // R9: reading a terminal result drops the interrupt
    a_r9_read_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && a == A_OUT + j && full[NB+j] && sink[j] |=> !irq_o);
  end

  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic          ld, fl;
    logic [DW-1:0] ld_d;
    if (s < NB) begin : g_in
      assign ld   = wr_en_i && a == s && !full[s] && (cons[s] != '0);
      assign fl   = 1'b0;
      assign ld_d = wdata_i;
    end else begin : g_out
      assign ld   = fire[s-NB];
      assign fl   = rd_en_i && a == s && full[s];
      assign ld_d = res[s-NB];
    end
    dfa_slot #(.DW(DW), .NA(NA)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .flush_i(fl), .data_i(ld_d),
      .mask_i(cons[s]), .clr_i(clr[s]), .full_o(full[s]), .pend_o(pend[s]), .data_o(sdata[s]));
  end

  assign wr_err = wr_en_i && ((a < NB && full[addr_i[SW-1:0]]) ||
                              (a >= A_CFG && a < A_STAT && !cfg_ok));
  assign rd_err = rd_en_i && a >= A_OUT && a < A_CFG && !full[addr_i[SW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else begin
      if (wr_en_i && a == A_STAT && wdata_i[ERR_BIT]) err_q <= 1'b0;
      if (wr_err || rd_err) err_q <= 1'b1;
    end
  end

  assign irq_o = (|active) && (&(~sink | full[NS-1:NB]));

  always_comb begin
    rdata_o = '0;
    if (a >= A_OUT && a < A_CFG) begin
      if (full[addr_i[SW-1:0]]) rdata_o = sdata[addr_i[SW-1:0]];
    end else if (a >= A_CFG && a < A_STAT) begin
      for (int j = 0; j < NA; j++)
        if (a == A_CFG + j) begin
          rdata_o[OPW-1:0]    = op_q[j];
          rdata_o[CF_L +: SW] = lsel_q[j];
          rdata_o[CF_R +: SW] = rsel_q[j];
        end
    end else if (a == A_STAT) begin
      rdata_o[NB-1:0] = full[NB-1:0];
      for (int j = 0; j < NA; j++)
        rdata_o[NB+2*j +: 2] = !active[j] ? ST_IDLE : (full[NB+j] ? ST_WAIT : ST_READY);
      rdata_o[ERR_BIT] = err_q;
    end
  end

  // R8: completion implies at least one held result
  a_r8_irq_has_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (full[NS-1:NB] != '0));
endmodule

// File: tb/dfa_array_test.sv
`timescale 1ns/1ps
module dfa_array_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dfa_array uut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
                 .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_data [8];
  int          m_pend [8];
  bit          m_full [8];
  int          m_op [4], m_l [4], m_r [4];
  bit          m_err;

  function automatic bit m_uses(int j, int s);
    return m_op[j] != 0 && (m_l[j] == s || (m_op[j] != 7 && m_r[j] == s));
  endfunction
  function automatic int m_cons(int s);
    int m = 0;
    for (int j = 0; j < 4; j++) if (m_uses(j, s)) m |= (1 << j);
    return m;
  endfunction
  function automatic logic [15:0] f_alu(int op, logic [15:0] x, logic [15:0] y);
    case (op)
      1: return x + y;
      2: return x - y;
      3: return x * y;
      4: return x & y;
      5: return x | y;
      6: return x ^ y;
      7: return ~x;
      default: return 16'h0;
    endcase
  endfunction
  function automatic bit m_irq();
    bit any = 0, ok = 1;
    for (int j = 0; j < 4; j++) if (m_op[j] != 0) begin
      any = 1;
      if (m_cons(4 + j) == 0 && !m_full[4 + j]) ok = 0;
    end
    return any && ok;
  endfunction
  function automatic logic [15:0] m_read(int ad);
    logic [15:0] v = 16'h0;
    if (ad >= 4 && ad < 8) v = m_full[ad] ? m_data[ad] : 16'h0;
    else if (ad >= 8 && ad < 12) v = 16'(m_op[ad-8] | (m_l[ad-8] << 4) | (m_r[ad-8] << 8));
    else if (ad == 12) begin
      for (int b = 0; b < 4; b++) v[b] = m_full[b];
      for (int j = 0; j < 4; j++)
        v[4+2*j +: 2] = (m_op[j] == 0) ? 2'd0 : (m_full[4+j] ? 2'd2 : 2'd1);
      v[12] = m_err;
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit          fire [4];
    logic [15:0] res [4];
    bit          anyfull;
    int          ad, clrm;
    if (!rst_n) begin
      for (int s = 0; s < 8; s++) begin m_data[s] = 0; m_pend[s] = 0; m_full[s] = 0; end
      for (int j = 0; j < 4; j++) begin m_op[j] = 0; m_l[j] = 0; m_r[j] = 0; end
      m_err = 0;
    end else begin
      ad = int'(addr);
      anyfull = 0;
      for (int s = 0; s < 8; s++) anyfull |= m_full[s];
      for (int j = 0; j < 4; j++) begin
        fire[j] = m_op[j] != 0 && !m_full[4+j] && m_pend[m_l[j]][j] &&
                  (m_op[j] == 7 || m_pend[m_r[j]][j]);
        res[j]  = f_alu(m_op[j], m_data[m_l[j]], m_data[m_r[j]]);
      end
      for (int s = 0; s < 8; s++) begin
        clrm = 0;
        for (int j = 0; j < 4; j++) if (fire[j] && m_uses(j, s)) clrm |= (1 << j);
        if ((m_pend[s] & clrm) != 0) begin
          m_pend[s] &= ~clrm;
          if (m_pend[s] == 0) m_full[s] = 0;
        end
      end
      for (int j = 0; j < 4; j++) if (fire[j]) begin
        m_full[4+j] = 1; m_data[4+j] = res[j]; m_pend[4+j] = m_cons(4+j);
      end
      if (wr_en && ad == 12 && wdata[12]) m_err = 0;
      if (wr_en && ad < 4) begin
        if (m_full[ad]) m_err = 1;
        else if (m_cons(ad) != 0) begin
          m_full[ad] = 1; m_data[ad] = wdata; m_pend[ad] = m_cons(ad);
        end
      end
      if (wr_en && ad >= 8 && ad < 12) begin
        if (anyfull) m_err = 1;
        else begin m_op[ad-8] = wdata[2:0]; m_l[ad-8] = wdata[6:4]; m_r[ad-8] = wdata[10:8]; end
      end
      if (rd_en && ad >= 4 && ad < 8) begin
        if (m_full[ad]) begin m_full[ad] = 0; m_pend[ad] = 0; end
        else m_err = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8 model irq", {15'b0, irq}, {15'b0, m_irq()});
    if (rd_en) chk("R9 model rdata", rdata, m_read(int'(addr)));
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int ad, input logic [15:0] d);
    wr_en = 1; addr = 4'(ad); wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic rd(input int ad, output logic [15:0] v);
    rd_en = 1; addr = 4'(ad);
    @(negedge clk); v = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1);
    // R1 reset state
    rd(12, v); chk("R1 status", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // single adder ALU0 = b0 + b1
    wr(8, 16'h0101);
    wr(0, 16'd5);
    rd(12, v); chk("R10 status one buffer full", v, 16'h0011);
    wr(1, 16'd7); idle(2);
    chk("R8 irq single", {15'b0, irq}, 16'h1);
    rd(12, v); chk("R10 status wait", v, 16'h0020);
    rd(4, v); chk("R4 add result", v, 16'd12);
    chk("R9 irq cleared", {15'b0, irq}, 16'h0);
    rd(4, v); chk("R9 empty read zero", v, 16'h0);
    rd(12, v); chk("R10 err sticky", v, 16'h1010);
    wr(12, 16'h1000);
    rd(12, v); chk("R10 err cleared", v, 16'h0010);

    // R3 overwrite of full buffer dropped
    wr(0, 16'd5); wr(0, 16'd9);
    rd(12, v); chk("R3 overwrite flagged", v, 16'h1011);
    wr(1, 16'd1); idle(2);
    rd(4, v); chk("R3 first value kept", v, 16'd6);
    wr(12, 16'h1000);

    // R5 write to unconsumed buffer dropped
    wr(2, 16'h0055);
    rd(12, v); chk("R5 unconsumed buffer empty", v, 16'h0010);

    // R2 config lock while data in flight
    wr(0, 16'd1);
    wr(9, 16'h0321);
    rd(12, v); chk("R2 config dropped", v, 16'h1011);
    wr(1, 16'd1); idle(2);
    rd(4, v); chk("R2 result after lock", v, 16'd2);
    wr(12, 16'h1000);

    // two parallel adders
    wr(9, 16'h0321);
    rd(9, v); chk("R2 config readback", v, 16'h0321);
    wr(0, 16'd2); wr(1, 16'd3); idle(3);
    chk("R8 irq waits for second sink", {15'b0, irq}, 16'h0);
    wr(2, 16'd4); wr(3, 16'd5); idle(3);
    chk("R8 irq both sinks", {15'b0, irq}, 16'h1);
    rd(4, v); chk("R4 parallel first", v, 16'd5);
    chk("R9 irq drops on read", {15'b0, irq}, 16'h0);
    rd(5, v); chk("R4 parallel second", v, 16'd9);
    rd(12, v); chk("R10 both ready", v, 16'h0050);

    // R7 chain (A+B)*C+D
    wr(9, 16'h0243); wr(10, 16'h0351);
    wr(2, 16'd5); wr(3, 16'd6); wr(0, 16'd3); wr(1, 16'd4);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R7 irq not before third stage", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R7 irq at third stage", {15'b0, irq}, 16'h1);
    @(posedge clk); #1;
    rd(6, v); chk("R7 chain result", v, 16'd41);
    rd(4, v); chk("R7 intermediate released", v, 16'h0);
    rd(12, v); chk("R7 status after chain", v, 16'h1150);
    wr(12, 16'h1000);

    // R6 shared source b0 feeding ALU0 and ALU1
    wr(10, 16'h0000); wr(9, 16'h0202);
    wr(0, 16'd10); wr(1, 16'd3); idle(2);
    rd(12, v); chk("R6 shared source held", v, 16'h0061);
    wr(2, 16'd4); idle(3);
    rd(12, v); chk("R6 shared source released", v, 16'h00A0);
    rd(4, v); chk("R6 first consumer", v, 16'd13);
    rd(5, v); chk("R6 second consumer", v, 16'd6);

    // R11 unary NOT ignores right select
    wr(9, 16'h0000); wr(8, 16'h0107);
    wr(0, 16'h00F0); wr(1, 16'h0033); idle(2);
    rd(12, v); chk("R11 right source not consumer", v, 16'h0020);
    rd(4, v); chk("R11 not result", v, 16'hFF0F);

    // R4 remaining opcodes on 5 and 3
    for (int k = 2; k <= 6; k++) begin
      logic [15:0] e;
      case (k)
        2: e = 16'd2;
        3: e = 16'd15;
        4: e = 16'd1;
        5: e = 16'd7;
        default: e = 16'd6;
      endcase
      wr(8, 16'h0100 | 16'(k));
      wr(0, 16'd5); wr(1, 16'd3); idle(2);
      rd(4, v); chk("R4 opcode", v, e);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule